// File: doc/BRIEF.md
# Fracturable LUT pair cell

This block is one pair of look-up table positions that can be split or merged. An even and an odd position share six input pins and one 64-bit truth table. A 2-bit mode field decides how the table is used. In the first mode the pair acts as one 6-input function, and the result appears only on the odd output. In the second mode it acts as two functions of the same five pins, with separate outputs. In the third mode it acts as two 3-input functions, each on its own three pins. Eight of these cells placed side by side make a 16-position slice.

The mode and the table are loaded through a one-bit serial port. While the load enable is held high, a small state machine shifts one bit per clock into a shadow register. After the last bit arrives, it copies the whole frame into the active configuration in one step. The machine has three states: ST_IDLE waits for the load enable. ST_SHIFT collects frame bits. ST_COMMIT copies the shadow into the active configuration. There are four transitions:
- ST_IDLE goes to ST_SHIFT when the load enable is high.
- ST_SHIFT goes back to ST_IDLE (an abort) when the load enable falls early.
- ST_SHIFT goes to ST_COMMIT when the final bit is taken.
- ST_COMMIT always goes to ST_IDLE.

The function outputs are purely combinational from the inputs and the active configuration.

Top module: `lut_pair_cell`

## Requirements
- R1: After reset the active mode is 01 (dual shared) with an all-zero table, so both outputs are 0 and cfg_err is 0 for every input value.
- R2: A frame is 66 bits shifted in least significant bit first, one bit per clock while cfg_load is high. Frame bits 0 to 63 are the table and bits 64 to 65 are the mode. The frame becomes active on the clock edge that follows the edge capturing bit 65.
- R3: If cfg_load falls before 66 bits are taken, the partial frame is discarded and the active configuration is unchanged. The next frame starts again from bit 0.
- R4: While a frame is being shifted in, the outputs keep following the previously active configuration.
- R5: In mode 00 (single 6-input), out_odd equals table[lut_in[5:0]] and out_even is 0.
- R6: In mode 01 (dual shared), out_even equals table[lut_in[4:0]] and out_odd equals table[32 + lut_in[4:0]]. lut_in[5] has no effect.
- R7: In mode 10 (dual split), out_even equals table[lut_in[2:0]] and out_odd equals table[8 + lut_in[5:3]]. Each output depends only on its own three pins.
- R8: Mode 11 is illegal: both outputs are 0 and cfg_err is 1. In every legal mode cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load enable; a frame bit is taken on each clock while high |
| cfg_sdi | input | 1 | Serial configuration data, least significant bit first |
| lut_in | input | 6 | Function input pins |
| out_even | output | 1 | Output of the even position |
| out_odd | output | 1 | Output of the odd position |
| cfg_err | output | 1 | High when the active mode code is illegal |

## Verification
A bit counter that is off by one would commit a frame shifted by one bit position. Every table entry and the mode field would then be misplaced, so the very first exhaustive input sweep after the commit would show wrong outputs. A state machine that failed to abort would carry partial bits into the next frame, and the sweep after that frame would reveal it. A commit that happened too early would disturb the outputs in the middle of a frame; this is sampled while the load is still in progress. An error in the mode decode shows up at once as an output that is wrong for some of the 64 input values.

// File: rtl/lutp_pkg.sv
package lutp_pkg;
    localparam int LUT_K    = 6;
    localparam int SMALL_K  = 3;
    localparam int TBL_W    = 1 << LUT_K;
    localparam int SMALL_W  = 1 << SMALL_K;
    localparam int MODE_W   = 2;
    localparam int FRAME_W  = TBL_W + MODE_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [MODE_W-1:0] {
        MODE_SINGLE       = 2'b00,
        MODE_DUAL_SHARED  = 2'b01,
        MODE_DUAL_SPLIT   = 2'b10,
        MODE_BAD          = 2'b11
    } lut_mode_e;

    typedef struct packed {
        lut_mode_e          mode;
        logic [TBL_W-1:0]   tbl;
    } lut_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/lutp_cfg_loader.sv
module lutp_cfg_loader
    import lutp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load_en,
    input  logic     sdi,
    output lut_cfg_t cfg_q
);
    ld_state_e          state, state_nx;
    logic [FRAME_W-1:0] shadow;
    logic [CNT_W-1:0]   bit_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (load_en) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (!load_en)                                 state_nx = ST_IDLE;
                else if (bit_cnt == CNT_W'(FRAME_W - 1))      state_nx = ST_COMMIT;
            end
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath / outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow     <= '0;
            bit_cnt    <= '0;
            cfg_q.mode <= MODE_DUAL_SHARED;
            cfg_q.tbl  <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SHIFT: begin
                    if (load_en) begin
                        shadow  <= {sdi, shadow[FRAME_W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        bit_cnt <= '0;
                    end
                end
                ST_COMMIT: begin
                    cfg_q   <= lut_cfg_t'(shadow);
                    bit_cnt <= '0;
                end
                default: bit_cnt <= '0;
            endcase
        end
    end

    // R2: a commit happens only with a complete frame
    a_r2_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |-> (bit_cnt == CNT_W'(FRAME_W)));
    // R3: an early drop of the load enable aborts the frame
    a_r3_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !load_en) |=> (state == ST_IDLE && bit_cnt == '0));
    // R4: the active configuration moves only when leaving commit
    a_r4_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(cfg_q));
endmodule

// File: rtl/lutp_eval.sv
module lutp_eval
    import lutp_pkg::*;
(
    input  lut_cfg_t         cfg,
    input  logic [LUT_K-1:0] pins,
    output logic             y_even,
    output logic             y_odd,
    output logic             bad_mode
);
    localparam int HALF_W = TBL_W / 2;

    logic [1:0] small_y;

    // one 3-input lookup per position, each on its own pin group
    for (genvar p = 0; p < 2; p++) begin : g_small
        logic [SMALL_W-1:0] sub_tbl;
        assign sub_tbl    = cfg.tbl[p*SMALL_W +: SMALL_W];
        assign small_y[p] = sub_tbl[pins[p*SMALL_K +: SMALL_K]];
    end

    logic [HALF_W-1:0] lo_half, hi_half;
    assign lo_half = cfg.tbl[HALF_W-1:0];
    assign hi_half = cfg.tbl[TBL_W-1:HALF_W];

    always_comb begin
        y_even   = 1'b0;
        y_odd    = 1'b0;
        bad_mode = 1'b0;
        unique case (cfg.mode)
            MODE_SINGLE:      y_odd = cfg.tbl[pins];
            MODE_DUAL_SHARED: begin
                y_even = lo_half[pins[LUT_K-2:0]];
                y_odd  = hi_half[pins[LUT_K-2:0]];
            end
            MODE_DUAL_SPLIT:  begin
                y_even = small_y[0];
                y_odd  = small_y[1];
            end
            MODE_BAD:         bad_mode = 1'b1;
            default:          bad_mode = 1'b1;
        endcase
    end
endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell
    import lutp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_sdi,
    input  logic [LUT_K-1:0] lut_in,
    output logic             out_even,
    output logic             out_odd,
    output logic             cfg_err
);
    lut_cfg_t act_cfg;

    lutp_cfg_loader u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (cfg_load),
        .sdi     (cfg_sdi),
        .cfg_q   (act_cfg)
    );

    lutp_eval u_eval (
        .cfg      (act_cfg),
        .pins     (lut_in),
        .y_even   (out_even),
        .y_odd    (out_odd),
        .bad_mode (cfg_err)
    );

    // R8: the error flag silences both outputs
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!out_even && !out_odd));
    // R8: the flag tracks the stored mode code
    a_r8_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err == (act_cfg.mode == MODE_BAD));
    // R5: the even partner is unused in single mode
    a_r5_even_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.mode == MODE_SINGLE) |-> !out_even);
endmodule

// File: tb/sim_lut_pair_cell.sv
module sim_lut_pair_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_sdi = 1'b0;
    logic [5:0] lut_in = '0;
    logic       out_even, out_odd, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [1:0]  cur_mode = 2'b01;
    logic [63:0] cur_tbl  = '0;

    always #4 clk = ~clk;

    lut_pair_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sdi(cfg_sdi),
        .lut_in(lut_in), .out_even(out_even), .out_odd(out_odd), .cfg_err(cfg_err)
    );

    // returns {err, odd, even}
    function automatic logic [2:0] model(input logic [1:0] m, input logic [63:0] t,
                                         input logic [5:0] x);
        case (m)
            2'b00: return {1'b0, t[x], 1'b0};
            2'b01: return {1'b0, t[32 + int'(x[4:0])], t[int'(x[4:0])]};
            2'b10: return {1'b0, t[8 + int'(x[5:3])], t[int'(x[2:0])]};
            default: return 3'b100;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s in=%0d actual=%b expected=%b", req, lut_in, act, exp);
        end
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < 64; x++) begin
            @(negedge clk);
            lut_in = 6'(x);
            #1;
            check(req, {cfg_err, out_odd, out_even}, model(cur_mode, cur_tbl, lut_in));
        end
    endtask

    // shifts nbits of frame; full frames become the expected config
    task automatic load(input logic [1:0] m, input logic [63:0] t, input int nbits);
        logic [65:0] fr;
        fr = {m, t};
        lut_in = 6'h2D;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_sdi  = fr[i];
            if (i == 40) begin
                #1;
                check("R4 mid-frame", {cfg_err, out_odd, out_even},
                      model(cur_mode, cur_tbl, lut_in));
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_sdi  = 1'b0;
        repeat (2) @(negedge clk);
        if (nbits == 66) begin
            cur_mode = m;
            cur_tbl  = t;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep("R1 reset");
        load(2'b00, 64'hA5C3_0F96_1234_FEDC, 66);
        sweep("R2 R5 single");
        load(2'b01, 64'h0F0F_3C3C_9999_6A6A, 66);
        sweep("R6 dual shared");
        load(2'b10, 64'h0000_0000_0000_B7E1, 66);
        sweep("R7 dual split");
        load(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 66);
        sweep("R8 illegal");
        load(2'b10, 64'hDEAD_BEEF_0000_4C2D, 66);
        sweep("R8 R7 recover");
        load(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 30);
        sweep("R3 abort keeps config");
        load(2'b01, 64'h8001_7FFE_C3A5_1E2F, 66);
        sweep("R3 restart from bit 0");
        load(2'b00, 64'h1357_9BDF_2468_ACE0, 66);
        sweep("R2 R5 second frame");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule